// File: doc/BRIEF.md
# Serial Character Transmitter with Clear-to-Send Gating

This block serialises one parallel character at a time onto an asynchronous serial line. A host writes a character into a single-entry holding register with a one-cycle load strobe. The transmitter takes the character from there and sends a start bit, then 5 to 8 data bits least significant bit first. An optional parity bit follows, and then a stop interval. The line rests at the high (mark) level whenever no character is in progress.

Bit timing comes from an external clock-enable pulse. In oversampled mode that pulse runs at sixteen times the bit rate, which allows stop intervals in sixteenths of a bit, including a 9/16-bit stop. In direct mode the pulse runs at the bit rate itself and only whole-bit stop intervals exist. An active-low clear-to-send input can hold back the start of each character. It is examined only at the moment a character would begin, so a character already on the line always finishes unchanged.

Frame settings (length, parity, stop code, clock mode) are sampled when a character starts and held for that whole character. The reset input is asynchronous and active low, and its release is synchronised internally over two clock cycles.

Top module: `ser_tx_cts`

## Requirements
- R1: After reset, and at any time no character is in progress, `txd` is 1, `busy` is 0, and `ready` is 1 when the holding register is empty.
- R2: A character is sent as one start bit at 0, then the data bits from bit 0 upward. The count of data bits is set by `char_len`: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. An optional parity bit comes next, and then a stop interval at 1.
- R3: When `par_en` is 1, the parity bit depends on `par_kind`. With 00 it makes the number of ones in the data plus parity even. With 01 it makes that number odd. With 10 it is forced to 0 and with 11 it is forced to 1. When `par_en` is 0, no parity bit is sent.
- R4: When `ext_1x` is 0, the start bit, each data bit and the parity bit each last 16 `baud_tick` pulses.
- R5: When `ext_1x` is 0, the stop interval depends on `stop_sel`. With 00 it lasts 9 pulses, except for 5-bit characters, where it lasts 16. With 01 it lasts 16 pulses, with 10 it lasts 24 and with 11 it lasts 32.
- R6: When `ext_1x` is 1, every bit lasts one `baud_tick` pulse. The stop interval is 2 bits when `stop_sel[1]` is 1 and 1 bit otherwise; `stop_sel[0]` has no effect.
- R7: When `cts_en` is 1 and `cts_n` is 1, no character starts. `txd` stays at 1, `busy` stays at 0, and the held character waits until `cts_n` goes to 0.
- R8: A change of `cts_n` after a character has started does not alter that character's bits or its duration.
- R9: When `cts_en` is 0, the value of `cts_n` has no effect, and a held character starts on the next pulse.
- R10: `ready` is 1 exactly while the holding register is empty. A load strobe while the register is full is ignored and does not replace the held character.
- R11: `busy` rises on the clock edge of the pulse that starts a character. It falls after the last pulse of the stop interval. A held character that may start then follows with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Bit-timing enable: 16x bit rate, or 1x in direct mode |
| ext_1x | input | 1 | 1 selects direct (1x) timing mode |
| ld | input | 1 | One-cycle strobe writing `ld_data` into the holding register |
| ld_data | input | 8 | Character to send; unused upper bits are ignored |
| char_len | input | 2 | Data bit count: 5 + value |
| par_en | input | 1 | 1 inserts a parity bit |
| par_kind | input | 2 | Parity kind: even, odd, forced 0, forced 1 |
| stop_sel | input | 2 | Stop interval code |
| cts_en | input | 1 | 1 makes character start depend on `cts_n` |
| cts_n | input | 1 | Active-low clear-to-send |
| txd | output | 1 | Serial data line, idles at 1 |
| ready | output | 1 | Holding register empty |
| busy | output | 1 | A character is on the line |

## Verification
The hardest case to reach is a clear-to-send change that lands while a character is already on the line. The bench sends a frame with clear-to-send enabled and raises `cts_n` twenty cycles after the start bit appears. It then checks that every bit and the total frame length match an undisturbed frame. A second hard case is the holding register staying full while the line is blocked. The bench keeps `cts_n` high, loads one character, loads another one that must be dropped, and checks that the line stays at mark. It then releases `cts_n` and confirms that the first character is the one sent.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_PAR,
    TX_STOP
  } tx_phase_t;

  typedef enum logic [1:0] {
    PK_EVEN = 2'b00,
    PK_ODD  = 2'b01,
    PK_ZERO = 2'b10,
    PK_ONE  = 2'b11
  } par_kind_t;

endpackage

// File: rtl/ser_tx_hold.sv
module ser_tx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] dout
);

  logic         full_q, full_d;
  logic [W-1:0] dat_q, dat_d;

  always_comb begin
    full_d = full_q;
    dat_d  = dat_q;
    if (take) begin
      full_d = 1'b0;
    end else if (load && !full_q) begin
      full_d = 1'b1;
      dat_d  = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      dat_q  <= '0;
    end else begin
      full_q <= full_d;
      dat_q  <= dat_d;
    end
  end

  assign full = full_q;
  assign dout = dat_q;

endmodule

// File: rtl/ser_tx_par.sv
module ser_tx_par
  import ser_tx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] data,
  input  logic [1:0]   len,
  input  logic [1:0]   kind,
  output logic         pbit
);

  localparam int MIN_BITS = W - 3;

  logic [W-1:0] mask;
  logic         odd_ones;

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign mask[i] = (i < (MIN_BITS + int'(len)));
  end

  assign odd_ones = ^(data & mask);

  always_comb begin
    case (par_kind_t'(kind))
      PK_EVEN: pbit = odd_ones;
      PK_ODD:  pbit = ~odd_ones;
      PK_ZERO: pbit = 1'b0;
      default: pbit = 1'b1;
    endcase
  end

endmodule

// File: rtl/ser_tx_stopcalc.sv
module ser_tx_stopcalc #(
  parameter int OVS = 16,
  parameter int CW  = 6
) (
  input  logic          one_x,
  input  logic [1:0]    len,
  input  logic [1:0]    sel,
  output logic [CW-1:0] stop_ticks,
  output logic [CW-1:0] bit_ticks
);

  localparam logic [CW-1:0] T_SHORT = CW'(OVS / 2 + 1);
  localparam logic [CW-1:0] T_ONE   = CW'(OVS);
  localparam logic [CW-1:0] T_HALF  = CW'(OVS + OVS / 2);
  localparam logic [CW-1:0] T_TWO   = CW'(2 * OVS);

  always_comb begin
    if (one_x) begin
      bit_ticks  = CW'(1);
      stop_ticks = sel[1] ? CW'(2) : CW'(1);
    end else begin
      bit_ticks = T_ONE;
      case (sel)
        2'b00:   stop_ticks = (len == 2'b00) ? T_ONE : T_SHORT;
        2'b01:   stop_ticks = T_ONE;
        2'b10:   stop_ticks = T_HALF;
        default: stop_ticks = T_TWO;
      endcase
    end
  end

endmodule

// File: rtl/ser_tx_engine.sv
module ser_tx_engine
  import ser_tx_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = 6,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          go,
  input  logic [W-1:0]  hold_data,
  input  logic [IW-1:0] last_idx_in,
  input  logic          pen_in,
  input  logic          pbit_in,
  input  logic [CW-1:0] stop_in,
  input  logic [CW-1:0] bitt_in,
  output logic          take,
  output logic          txd,
  output logic          busy
);

  tx_phase_t     ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [W-1:0]  sh_q, sh_d;
  logic          txd_q, txd_d;
  logic [IW-1:0] last_q, last_d;
  logic          pen_q, pen_d;
  logic          pbit_q, pbit_d;
  logic [CW-1:0] stop_q, stop_d;
  logic [CW-1:0] bitt_q, bitt_d;
  logic [CW-1:0] span;
  logic          span_end;

  assign span     = (ph_q == TX_STOP) ? stop_q : bitt_q;
  assign span_end = (cnt_q == span - CW'(1));

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    txd_d  = txd_q;
    last_d = last_q;
    pen_d  = pen_q;
    pbit_d = pbit_q;
    stop_d = stop_q;
    bitt_d = bitt_q;
    take   = 1'b0;

    if (tick) begin
      if (ph_q == TX_IDLE || (ph_q == TX_STOP && span_end)) begin
        if (go) begin
          take   = 1'b1;
          ph_d   = TX_START;
          cnt_d  = '0;
          sh_d   = hold_data;
          txd_d  = 1'b0;
          last_d = last_idx_in;
          pen_d  = pen_in;
          pbit_d = pbit_in;
          stop_d = stop_in;
          bitt_d = bitt_in;
        end else begin
          ph_d  = TX_IDLE;
          cnt_d = '0;
          txd_d = 1'b1;
        end
      end else if (!span_end) begin
        cnt_d = cnt_q + CW'(1);
      end else begin
        cnt_d = '0;
        case (ph_q)
          TX_START: begin
            ph_d  = TX_DATA;
            idx_d = '0;
            txd_d = sh_q[0];
          end
          TX_DATA: begin
            if (idx_q == last_q) begin
              if (pen_q) begin
                ph_d  = TX_PAR;
                txd_d = pbit_q;
              end else begin
                ph_d  = TX_STOP;
                txd_d = 1'b1;
              end
            end else begin
              idx_d = idx_q + IW'(1);
              sh_d  = sh_q >> 1;
              txd_d = sh_q[1];
            end
          end
          TX_PAR: begin
            ph_d  = TX_STOP;
            txd_d = 1'b1;
          end
          default: begin
            ph_d  = TX_IDLE;
            txd_d = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= TX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      txd_q  <= 1'b1;
      last_q <= '0;
      pen_q  <= 1'b0;
      pbit_q <= 1'b0;
      stop_q <= '0;
      bitt_q <= '0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      txd_q  <= txd_d;
      last_q <= last_d;
      pen_q  <= pen_d;
      pbit_q <= pbit_d;
      stop_q <= stop_d;
      bitt_q <= bitt_d;
    end
  end

  assign txd  = txd_q;
  assign busy = (ph_q != TX_IDLE);

endmodule

// File: rtl/ser_tx_cts.sv
module ser_tx_cts #(
  parameter int W   = 8,
  parameter int OVS = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         baud_tick,
  input  logic         ext_1x,
  input  logic         ld,
  input  logic [W-1:0] ld_data,
  input  logic [1:0]   char_len,
  input  logic         par_en,
  input  logic [1:0]   par_kind,
  input  logic [1:0]   stop_sel,
  input  logic         cts_en,
  input  logic         cts_n,
  output logic         txd,
  output logic         ready,
  output logic         busy
);

  localparam int CW       = $clog2(2 * OVS + 1);
  localparam int IW       = $clog2(W);
  localparam int MIN_BITS = W - 3;

  logic [1:0]    rs_q;
  logic          rst_i;
  logic          hold_full;
  logic [W-1:0]  hold_data;
  logic          take;
  logic          go;
  logic          pbit;
  logic [CW-1:0] stop_ticks;
  logic [CW-1:0] bit_ticks;
  logic [IW-1:0] last_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_i = rs_q[1];

  assign go       = hold_full & (~cts_en | ~cts_n);
  assign last_idx = IW'(MIN_BITS - 1) + IW'(char_len);

  ser_tx_hold #(.W(W)) u_hold (
    .clk  (clk),
    .rst_n(rst_i),
    .load (ld),
    .din  (ld_data),
    .take (take),
    .full (hold_full),
    .dout (hold_data)
  );

  ser_tx_par #(.W(W)) u_par (
    .data(hold_data),
    .len (char_len),
    .kind(par_kind),
    .pbit(pbit)
  );

  ser_tx_stopcalc #(.OVS(OVS), .CW(CW)) u_stop (
    .one_x     (ext_1x),
    .len       (char_len),
    .sel       (stop_sel),
    .stop_ticks(stop_ticks),
    .bit_ticks (bit_ticks)
  );

  ser_tx_engine #(.W(W), .CW(CW), .IW(IW)) u_eng (
    .clk        (clk),
    .rst_n      (rst_i),
    .tick       (baud_tick),
    .go         (go),
    .hold_data  (hold_data),
    .last_idx_in(last_idx),
    .pen_in     (par_en),
    .pbit_in    (pbit),
    .stop_in    (stop_ticks),
    .bitt_in    (bit_ticks),
    .take       (take),
    .txd        (txd),
    .busy       (busy)
  );

  assign ready = ~hold_full;

endmodule

// File: rtl/ser_tx_cts_chk.sv
module ser_tx_cts_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic ld,
  input logic cts_en,
  input logic cts_n,
  input logic txd,
  input logic ready,
  input logic busy
);

  p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  p_tick_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(txd));

  p_cts_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cts_en && cts_n) |=> !busy);

  p_fill_by_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(ld));

  p_start_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ready);

  p_busy_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(baud_tick));

endmodule

bind ser_tx_cts ser_tx_cts_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .baud_tick(baud_tick),
  .ld       (ld),
  .cts_en   (cts_en),
  .cts_n    (cts_n),
  .txd      (txd),
  .ready    (ready),
  .busy     (busy)
);

// File: tb/sim_ser_tx_cts.sv
module sim_ser_tx_cts;

  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;
  localparam int REC_MAX    = 2048;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       ext_1x = 1'b0;
  logic       ld = 1'b0;
  logic [7:0] ld_data = 8'h00;
  logic [1:0] char_len = 2'b11;
  logic       par_en = 1'b0;
  logic [1:0] par_kind = 2'b00;
  logic [1:0] stop_sel = 2'b01;
  logic       cts_en = 1'b0;
  logic       cts_n = 1'b0;
  logic       txd, ready, busy;

  int  checks = 0;
  int  fails = 0;
  int  tcnt = 0;
  bit  done = 0;
  logic rec [REC_MAX];

  ser_tx_cts u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .ext_1x(ext_1x),
    .ld(ld), .ld_data(ld_data), .char_len(char_len), .par_en(par_en),
    .par_kind(par_kind), .stop_sel(stop_sel), .cts_en(cts_en),
    .cts_n(cts_n), .txd(txd), .ready(ready), .busy(busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (tcnt == TDIV - 1) begin
      baud_tick = 1'b1;
      tcnt = 0;
    end else begin
      baud_tick = 1'b0;
      tcnt = tcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_char(input logic [7:0] d);
    @(negedge clk);
    ld_data = d;
    ld = 1'b1;
    @(negedge clk);
    ld = 1'b0;
  endtask

  // waits for busy, records txd while busy; raises cts_n at sample flip_at
  task automatic capture(input int flip_at, output int n);
    int guard = 0;
    n = 0;
    while (!busy && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    while (busy && n < REC_MAX) begin
      rec[n] = txd;
      if (n == flip_at) cts_n = 1'b1;
      n++;
      @(negedge clk);
    end
  endtask

  function automatic int stop_expect(input bit onex, input logic [1:0] len,
                                     input logic [1:0] sel);
    if (onex) return sel[1] ? 2 : 1;
    case (sel)
      2'b00:   return (len == 2'b00) ? 16 : 9;
      2'b01:   return 16;
      2'b10:   return 24;
      default: return 32;
    endcase
  endfunction

  // sends one character and checks bits, parity, stop level and duration
  task automatic send_check(input logic [7:0] d, input logic [1:0] len,
                            input bit pen, input logic [1:0] pk,
                            input logic [1:0] sel, input bit onex,
                            input int flip_at, input string dreq);
    int nb, bt, bitc, st, n, exp_n, bad, ones;
    logic pexp;
    nb = 5 + int'(len);
    bt = onex ? 1 : 16;
    bitc = bt * TDIV;
    st = stop_expect(onex, len, sel);
    @(negedge clk);
    char_len = len; par_en = pen; par_kind = pk; stop_sel = sel; ext_1x = onex;
    load_char(d);
    capture(flip_at, n);
    exp_n = ((1 + nb + (pen ? 1 : 0)) * bt + st) * TDIV;
    chk(n == exp_n, dreq, n, exp_n);
    if (n > bitc / 2)
      chk(rec[bitc / 2] == 1'b0, "R2 start bit", int'(rec[bitc / 2]), 0);
    ones = 0;
    for (int k = 0; k < nb; k++) begin
      int idx = (1 + k) * bitc + bitc / 2;
      if (idx < n)
        chk(rec[idx] == d[k], "R2 data bit", int'(rec[idx]), int'(d[k]));
      else
        chk(1'b0, "R2 data bit missing", idx, n);
      ones += int'(d[k]);
    end
    if (pen) begin
      int idx = (1 + nb) * bitc + bitc / 2;
      case (pk)
        2'b00:   pexp = (ones % 2) != 0;
        2'b01:   pexp = (ones % 2) == 0;
        2'b10:   pexp = 1'b0;
        default: pexp = 1'b1;
      endcase
      chk(idx < n && rec[idx] == pexp, "R3 parity bit",
          (idx < n) ? int'(rec[idx]) : -1, int'(pexp));
    end
    bad = 0;
    for (int i = (1 + nb + (pen ? 1 : 0)) * bitc; i < n; i++)
      if (rec[i] !== 1'b1) bad++;
    chk(bad == 0, "R2 stop level", bad, 0);
    @(negedge clk);
    chk(txd == 1'b1 && busy == 1'b0 && ready == 1'b1, "R1 idle after frame",
        {txd, busy, ready}, 3'b101);
  endtask

  task automatic t_reset();
    chk(txd == 1'b1, "R1 reset txd", int'(txd), 1);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    chk(ready == 1'b1, "R1 reset ready", int'(ready), 1);
  endtask

  task automatic t_frames();
    send_check(8'hA5, 2'b11, 1'b0, 2'b00, 2'b01, 1'b0, -1, "R4 8-bit 1 stop");
    send_check(8'h37, 2'b11, 1'b1, 2'b00, 2'b01, 1'b0, -1, "R3 even parity");
    send_check(8'h55, 2'b10, 1'b1, 2'b01, 2'b01, 1'b0, -1, "R3 odd parity");
    send_check(8'h2D, 2'b01, 1'b1, 2'b10, 2'b01, 1'b0, -1, "R3 forced zero");
    send_check(8'hF3, 2'b00, 1'b1, 2'b11, 2'b01, 1'b0, -1, "R3 forced one");
  endtask

  task automatic t_stops();
    send_check(8'h81, 2'b11, 1'b0, 2'b00, 2'b00, 1'b0, -1, "R5 9/16 stop");
    send_check(8'h13, 2'b00, 1'b0, 2'b00, 2'b00, 1'b0, -1, "R5 5-bit code00");
    send_check(8'h3C, 2'b01, 1'b0, 2'b00, 2'b10, 1'b0, -1, "R5 1.5 stop");
    send_check(8'h7E, 2'b10, 1'b1, 2'b01, 2'b11, 1'b0, -1, "R5 2 stop");
  endtask

  task automatic t_onex();
    send_check(8'hC6, 2'b11, 1'b0, 2'b00, 2'b01, 1'b1, -1, "R6 1x one stop");
    send_check(8'h59, 2'b11, 1'b1, 2'b00, 2'b11, 1'b1, -1, "R6 1x two stop");
    send_check(8'h0F, 2'b10, 1'b0, 2'b00, 2'b00, 1'b1, -1, "R6 1x code00");
    ext_1x = 1'b0;
  endtask

  task automatic t_cts_hold();
    int bad = 0;
    int n;
    @(negedge clk);
    cts_en = 1'b1; cts_n = 1'b1;
    char_len = 2'b11; par_en = 1'b0; stop_sel = 2'b01;
    load_char(8'h6B);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || busy !== 1'b0) bad++;
    end
    chk(bad == 0, "R7 line held at mark", bad, 0);
    chk(ready == 1'b0, "R10 ready low while held", int'(ready), 0);
    load_char(8'h94);
    chk(ready == 1'b0, "R10 second load ignored", int'(ready), 0);
    @(negedge clk);
    cts_n = 1'b0;
    capture(-1, n);
    chk(n == 10 * 16 * TDIV, "R7 frame after release", n, 10 * 16 * TDIV);
    for (int k = 0; k < 8; k++) begin
      int idx = (1 + k) * 64 + 32;
      logic b = (idx < n) ? rec[idx] : 1'bx;
      chk(b === ((8'h6B >> k) & 1), "R10 held character kept", int'(b),
          int'((8'h6B >> k) & 1));
    end
    @(negedge clk);
    chk(ready == 1'b1 && busy == 1'b0, "R10 empty after send",
        {ready, busy}, 2'b10);
  endtask

  task automatic t_cts_mid();
    @(negedge clk);
    cts_en = 1'b1; cts_n = 1'b0;
    send_check(8'hB2, 2'b11, 1'b1, 2'b00, 2'b10, 1'b0, 20, "R8 cts mid frame");
    cts_n = 1'b0;
  endtask

  task automatic t_cts_off();
    @(negedge clk);
    cts_en = 1'b0; cts_n = 1'b1;
    send_check(8'h4E, 2'b11, 1'b0, 2'b00, 2'b01, 1'b0, -1, "R9 cts ignored");
    cts_n = 1'b0;
  endtask

  task automatic t_back_to_back();
    int n1, gap;
    @(negedge clk);
    cts_en = 1'b0; ext_1x = 1'b0;
    char_len = 2'b11; par_en = 1'b0; stop_sel = 2'b01;
    load_char(8'h11);
    capture(-1, n1);
    load_char(8'h22);
    n1 = 0;
    while (!busy && n1 < 4000) begin @(negedge clk); n1++; end
    // busy visible; now queue another while the second is on the line
    load_char(8'h33);
    gap = 0;
    while (busy && gap < 4000) begin @(negedge clk); gap++; end
    // busy must stay high through second and third frames without a gap
    chk(gap > 10 * 64 && busy == 1'b0, "R11 no idle gap", gap, 2 * 640 - 2);
    chk(gap == 2 * 640 - 2, "R11 chained length", gap, 2 * 640 - 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_frames();
    t_stops();
    t_onex();
    t_cts_hold();
    t_cts_mid();
    t_cts_off();
    t_back_to_back();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule